// File: doc/BRIEF.md
# Multi-mode logarithmic barrel shifter

This block is the shift unit of a processor ALU. It takes a 32-bit data word (operand A), a second operand whose five least significant bits give the shift distance, and a 2-bit mode code. It returns the shifted word in the same evaluation. It has no clock and no state.

The datapath is one cascade of five fixed-distance stages. The stages move the word by 1, 2, 4, 8 and 16 positions, in that order. Each stage has a 2-way multiplexer. One bit of the shift distance steers it to pass either the moved word or the unmoved word. All modes share the cascade. The mode sets the direction of travel and the bit that fills the vacated positions.

Top module: `barrel_shift_unit`

## Requirements
- R1: Mode code 2'b00 is a logical left shift. The result is `opa` moved toward the MSB by the shift distance, and the vacated low-order bits are 0.
- R2: Mode code 2'b01 is a logical right shift. The result is `opa` moved toward the LSB by the shift distance, and the vacated high-order bits are 0. For example, 0x000000F0 shifted by 2 gives 0x0000003C.
- R3: Mode code 2'b10 is an arithmetic right shift. The vacated high-order bits are copies of `opa[31]`, so 0x80000000 shifted by 31 gives 0xFFFFFFFF.
- R4: The shift distance is `opb[4:0]` only. Bits `opb[31:5]` have no effect on `result`.
- R5: A shift distance of 0 returns `opa` unchanged in every mode.
- R6: Mode code 2'b11 returns `opa` unchanged for any shift distance.
- R7: Every distance from 0 to 31 is correct in each shift mode. A distance is the sum of the stage distances selected by its set bits, so 3 is a shift by 2 plus a shift by 1.
- R8: The unit is purely combinational. `result` follows a change on any input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | Data word to be shifted |
| opb | input | 32 | Second operand; bits [4:0] are the shift distance |
| mode | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 pass |
| result | output | 32 | Shifted word |

## Verification
The bench sweeps all 32 distances in every mode code. It uses data words with bit 31 both clear and set, so a stage that skips its select bit, or that fills with the wrong value, shows up at one specific distance. Arithmetic shifts of negative words catch a unit that fills with zero instead of the sign, and a shift of 31 catches a sign copy that does not reach the last stage. The high bits of `opb` are held at random nonzero values. A unit that reads more than five distance bits therefore gives a wrong result at distance 0. Directed cases check that code 11 passes the word through, and that a logical shift by 31 keeps only the one surviving bit.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef enum logic [1:0] {
    SH_LEFT_LOG  = 2'b00,
    SH_RIGHT_LOG = 2'b01,
    SH_RIGHT_ARI = 2'b10,
    SH_PASS      = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       sign_bit,
  output logic       go_left,
  output logic       fill_bit,
  output logic       active
);
  shift_mode_e mode_e;
  assign mode_e = shift_mode_e'(mode);

  always_comb begin
    go_left  = 1'b0;
    fill_bit = 1'b0;
    active   = 1'b1;
    case (mode_e)
      SH_LEFT_LOG:  go_left  = 1'b1;
      SH_RIGHT_LOG: fill_bit = 1'b0;
      SH_RIGHT_ARI: fill_bit = sign_bit;
      default:      active   = 1'b0;
    endcase
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int DATA_W = 32,
  parameter int DIST   = 1
) (
  input  logic [DATA_W-1:0] din,
  input  logic              en,
  input  logic              go_left,
  input  logic              fill_bit,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] moved_l;
  logic [DATA_W-1:0] moved_r;
  logic [DATA_W-1:0] moved;

  assign moved_l = {din[DATA_W-DIST-1:0], {DIST{1'b0}}};
  assign moved_r = {{DIST{fill_bit}}, din[DATA_W-1:DIST]};
  assign moved   = go_left ? moved_l : moved_r;
  assign dout    = en ? moved : din;
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
  parameter int DATA_W = 32,
  parameter int OPB_W  = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [OPB_W-1:0]  opb,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] result
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [AMT_W-1:0]  amt;
  logic              go_left;
  logic              fill_bit;
  logic              active;
  logic [DATA_W-1:0] chain [0:AMT_W];
  logic              unused_opb_hi;

  assign amt           = opb[AMT_W-1:0];
  assign unused_opb_hi = ^opb[OPB_W-1:AMT_W];

  shift_ctrl u_ctrl (
    .mode     (mode),
    .sign_bit (opa[DATA_W-1]),
    .go_left  (go_left),
    .fill_bit (fill_bit),
    .active   (active)
  );

  assign chain[0] = opa;

  generate
    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
      shift_stage #(
        .DATA_W (DATA_W),
        .DIST   (1 << i)
      ) u_stage (
        .din      (chain[i]),
        .en       (active & amt[i]),
        .go_left  (go_left),
        .fill_bit (fill_bit),
        .dout     (chain[i+1])
      );
    end
  endgenerate

  assign result = chain[AMT_W];

  logic [DATA_W-1:0] hi_mask;
  logic [DATA_W-1:0] lo_mask;
  assign hi_mask = ~({DATA_W{1'b1}} >> amt);
  assign lo_mask = ~({DATA_W{1'b1}} << amt);

  always_comb begin
    if (mode == 2'b00)
      assert_left_zero_fill_R1: assert ((result & lo_mask) == '0);
    if (mode == 2'b01)
      assert_right_zero_fill_R2: assert ((result & hi_mask) == '0);
    if (mode == 2'b10)
      assert_arith_sign_fill_R3: assert ((result & hi_mask) == (opa[DATA_W-1] ? hi_mask : '0));
    if (amt == '0)
      assert_zero_amount_identity_R5: assert (result == opa);
    if (mode == 2'b11)
      assert_pass_mode_R6: assert (result == opa);
  end
endmodule

// File: tb/barrel_shift_unit_tb.sv
module barrel_shift_unit_tb;
  logic        clk = 1'b0;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [1:0]  mode;
  logic [31:0] result;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  barrel_shift_unit u_dut (.opa(opa), .opb(opb), .mode(mode), .result(result));

  localparam logic [31:0] DATA_TBL [0:7] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
    32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0001, 32'hA5A5_5A5A
  };

  function automatic logic [31:0] ref_shift(logic [31:0] a, logic [31:0] b, logic [1:0] m);
    logic [4:0] d;
    d = b[4:0];
    case (m)
      2'b00:   return a << d;
      2'b01:   return a >> d;
      2'b10:   return $unsigned($signed(a) >>> d);
      default: return a;
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s opa=%h opb=%h mode=%b got=%h exp=%h", tag, opa, opb, mode, result, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [1:0] m);
    opa = a; opb = b; mode = m;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    apply(32'h0, 32'h0, 2'b00);
    check("R5 idle zero", 32'h0);

    // table sweep: every word, every mode, every distance (R7, R4 via random high bits)
    foreach (DATA_TBL[k]) begin
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 32; d++) begin
          logic [31:0] b;
          b = {$urandom() | 32'h20, 5'b0} | 32'(d);
          b[31:5] = b[31:5] | 27'h1;
          apply(DATA_TBL[k], b, 2'(m));
          check($sformatf("%s R7 R4 d=%0d", mode_tag(2'(m)), d), ref_shift(DATA_TBL[k], b, 2'(m)));
        end
      end
    end

    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [1:0]  m;
      a = $urandom(); b = $urandom(); m = 2'($urandom());
      apply(a, b, m);
      check($sformatf("%s R7 random", mode_tag(m)), ref_shift(a, b, m));
    end

    apply(32'h0000_00F0, 32'd2, 2'b01);          check("R2 F0>>2", 32'h0000_003C);
    apply(32'h0000_0001, 32'd31, 2'b00);         check("R1 1<<31", 32'h8000_0000);
    apply(32'h8000_0000, 32'd31, 2'b10);         check("R3 sign to all", 32'hFFFF_FFFF);
    apply(32'h8000_0000, 32'd31, 2'b01);         check("R2 zero fill 31", 32'h0000_0001);
    apply(32'h8000_0080, 32'd3, 2'b10);          check("R7 three is two plus one", 32'hF000_0010);
    apply(32'h7000_0000, 32'd4, 2'b10);          check("R3 positive fills zero", 32'h0700_0000);
    apply(32'hCAFE_F00D, 32'hFFFF_FFE0, 2'b00);  check("R4 high bits only, left", 32'hCAFE_F00D);
    apply(32'hCAFE_F00D, 32'hFFFF_FFE0, 2'b10);  check("R5 zero distance arith", 32'hCAFE_F00D);
    apply(32'hCAFE_F00D, 32'h0000_0025, 2'b01);  check("R4 bit5 ignored", 32'h0657_F780);
    apply(32'hCAFE_F00D, 32'd5, 2'b11);          check("R6 pass code", 32'hCAFE_F00D);

    // R8: change inputs between clock edges and observe before the next edge
    @(negedge clk);
    apply(32'h0000_0010, 32'd4, 2'b01);          check("R8 no clock needed", 32'h0000_0001);
    apply(32'h0000_0010, 32'd3, 2'b00);          check("R8 follows input", 32'h0000_0080);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule